// File: doc/BRIEF.md
# Card-Clock Trigger Sequencer

This block produces a trigger pulse at a chosen point in half-duplex smartcard traffic. It does not act as a host. It only watches two signals: the single shared data wire and the clock that the reader supplies to the card. Every register in the block runs on that card clock, and the data wire is sampled only on that clock. The baud rate can change during a session, so no bit period is assumed anywhere.

The position of the trigger is described as a short list of up to four segments, which run one after another. There are two kinds of segment:

- An edge segment counts low-to-high transitions on the data wire. It is used to lock onto traffic whose content is fixed. Bytes that the card echoes back to the reader produce edges too, and those edges are counted.
- A cycle segment counts card clock cycles. It is used to step over bytes whose value varies but whose length is known.

When the last programmed segment completes, the trigger is raised for a programmable number of cycles. The block then waits until it is armed again. The same command stream always produces the trigger on the same card clock cycle.

Top module: `cardtrig_seq`

## Requirements
- R1: The data wire is registered on the card clock. A rising edge is detected when the previous sample is 0 and the current sample is 1. A rise applied to `io_line` before card clock edge n is counted at edge n+1.
- R2: An edge segment (`seg_kind` bit = 0) advances by one for each detected rising edge. A cycle segment (`seg_kind` bit = 1) advances by one on every card clock, whatever the data wire does.
- R3: Segment i takes its kind from `seg_kind[i]` and its length from `seg_len[16*i +: 16]`. Segments run in increasing index from 0. The segment whose index equals `seg_last` is the final one, and segments above it are never used.
- R4: A segment of length zero completes one cycle after it is entered and counts nothing.
- R5: `trig` rises in the cycle after the final count is reached. It stays high for `fire_len` cycles, and a value of 0 is taken as 1. It then stays low until the next arm.
- R6: `arm` is accepted only when the block is idle or finished. Acceptance captures `seg_kind`, `seg_len`, `seg_last` and `fire_len`. Changes to `arm` or to those inputs while counting or firing have no effect on the trigger.
- R7: While `rst_n` is low the block is idle and `trig` is low. After reset is released, nothing happens until `arm` is asserted.
- R8: An event that arrives in the same cycle as a segment's completion is consumed by that segment and is not credited to the next one.
- R9: Replaying the same stimulus after re-arming places the trigger on the same cycle with the same width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| card_clk | input | 1 | Card clock; the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start a new sequence from segment 0 |
| io_line | input | 1 | Half-duplex data wire, sampled on card_clk |
| seg_kind | input | NSEG | Per-segment kind: 0 edges, 1 clock cycles |
| seg_len | input | NSEG*CW | Per-segment target count, CW bits each |
| seg_last | input | IW | Index of the final segment |
| fire_len | input | PW | Trigger width in cycles (0 means 1) |
| trig | output | 1 | Trigger pulse |

## Verification
Two functions can fall in the same card clock cycle: a cycle segment finishing, and a data-wire rising edge being detected. The bench provokes this by programming a 5-cycle segment that ends on exactly the cycle in which the first rising edge is counted, followed by a one-edge segment. If the edge were wrongly credited to the following segment, the trigger would appear at cycle 6. The check requires it at cycle 11, the next rising edge. The same timing is used to inject arm and configuration changes during counting and during the pulse, and the trigger's position and width are required to stay unchanged.

// File: rtl/cardtrig_seq.sv
module cardtrig_seq #(
  parameter int NSEG = 4,
  parameter int CW   = 16,
  parameter int PW   = 8,
  localparam int IW  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic                 card_clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic                 io_line,
  input  logic [NSEG-1:0]      seg_kind,
  input  logic [NSEG*CW-1:0]   seg_len,
  input  logic [IW-1:0]        seg_last,
  input  logic [PW-1:0]        fire_len,
  output logic                 trig
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIRE, S_DONE} st_t;
  st_t st;

  logic              io_q, io_prev;
  logic [NSEG-1:0]   kind_r;
  logic [NSEG*CW-1:0] len_r;
  logic [IW-1:0]     last_r, idx;
  logic [PW-1:0]     width_r, wcnt;
  logic [CW-1:0]     cnt;

  wire          rise    = io_q & ~io_prev;
  wire [CW-1:0] cur_len = len_r[idx*CW +: CW];
  wire          cur_cyc = kind_r[idx];
  wire          step    = cur_cyc | rise;
  wire [CW-1:0] cnt_nx  = cnt + CW'(1);
  wire          seg_end = (cur_len == '0) | (step & (cnt_nx == cur_len));
  wire          can_arm = (st == S_IDLE) | (st == S_DONE);

  always_ff @(posedge card_clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      io_q    <= 1'b0;
      io_prev <= 1'b0;
      kind_r  <= '0;
      len_r   <= '0;
      last_r  <= '0;
      width_r <= PW'(1);
      wcnt    <= '0;
      idx     <= '0;
      cnt     <= '0;
      trig    <= 1'b0;
    end else begin
      io_q    <= io_line;
      io_prev <= io_q;
      case (st)
        S_IDLE, S_DONE: begin
          if (arm) begin
            kind_r  <= seg_kind;
            len_r   <= seg_len;
            last_r  <= seg_last;
            width_r <= (fire_len == '0) ? PW'(1) : fire_len;
            idx     <= '0;
            cnt     <= '0;
            st      <= S_RUN;
          end
        end
        S_RUN: begin
          if (seg_end) begin
            cnt <= '0;
            if (idx == last_r) begin
              st   <= S_FIRE;
              trig <= 1'b1;
              wcnt <= width_r;
            end else begin
              idx <= idx + IW'(1);
            end
          end else if (step) begin
            cnt <= cnt_nx;
          end
        end
        S_FIRE: begin
          if (wcnt == PW'(1)) begin
            trig <= 1'b0;
            st   <= S_DONE;
          end else begin
            wcnt <= wcnt - PW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: within one segment the count moves by at most one per cycle
  p_count_step_r2: assert property (@(posedge card_clk) disable iff (!rst_n)
    (st == S_RUN && $past(st) == S_RUN && $past(idx) == idx && !$past(seg_end))
      |-> (cnt == $past(cnt) || cnt == $past(cnt) + CW'(1)));

  // R2: a cycle segment advances every clock
  p_cycle_adv_r2: assert property (@(posedge card_clk) disable iff (!rst_n)
    (st == S_RUN && $past(st) == S_RUN && $past(cur_cyc) && !$past(seg_end))
      |-> cnt == $past(cnt) + CW'(1));

  // R3: segment index only moves forward by one
  p_order_r3: assert property (@(posedge card_clk) disable iff (!rst_n)
    (st == S_RUN && $past(st) == S_RUN) |-> (idx == $past(idx) || idx == $past(idx) + IW'(1)));

  // R4: an empty segment is left on the next edge
  p_zero_len_r4: assert property (@(posedge card_clk) disable iff (!rst_n)
    (st == S_RUN && cur_len == '0) |=> (st == S_FIRE || idx != $past(idx)));

  // R5: the pulse starts only out of counting and is silent when finished
  p_trig_from_run_r5: assert property (@(posedge card_clk) disable iff (!rst_n)
    $rose(trig) |-> ($past(st) == S_RUN && st == S_FIRE));
  p_quiet_done_r5: assert property (@(posedge card_clk) disable iff (!rst_n)
    (st == S_DONE) |-> !trig);

  // R6: captured programming is frozen while busy
  p_cfg_frozen_r6: assert property (@(posedge card_clk) disable iff (!rst_n)
    (!can_arm && $past(st) != S_IDLE && $past(st) != S_DONE)
      |-> ($stable(len_r) && $stable(kind_r) && $stable(last_r) && $stable(width_r)));

endmodule

// File: tb/cardtrig_seq_test.sv
module cardtrig_seq_test;
  localparam int NSEG = 4, CW = 16, PW = 8, IW = 2, H = 3, NV = 13, WIN = 60;

  localparam int KIND [NV]    = '{0, 1, 2, 1, 2, 10, 1, 1, 0, 1, 1, 10, 10};
  localparam int LEN  [NV][4] = '{'{3,0,0,0}, '{10,0,0,0}, '{2,5,0,0}, '{4,2,0,0},
                                  '{0,3,0,0}, '{1,2,1,3}, '{1,0,0,0}, '{2,100,0,0},
                                  '{0,0,0,0}, '{5,1,0,0}, '{10,0,0,0}, '{1,2,1,3},
                                  '{1,2,1,3}};
  localparam int LAST [NV]    = '{0, 0, 1, 1, 1, 3, 0, 0, 3, 1, 0, 3, 3};
  localparam int FW   [NV]    = '{1, 1, 2, 1, 1, 3, 0, 1, 1, 1, 1, 3, 3};
  localparam int EF   [NV]    = '{17, 10, 16, 11, 4, 14, 1, 2, 4, 11, 10, 14, 14};
  localparam int EW   [NV]    = '{1, 1, 2, 1, 1, 3, 1, 1, 1, 1, 1, 3, 3};
  localparam int POKE [NV]    = '{-1, -1, -1, -1, -1, -1, -1, -1, -1, -1, 3, 15, -1};
  localparam string TAG [NV]  = '{"R2", "R2", "R3", "R1", "R4", "R3", "R5", "R3",
                                  "R4", "R8", "R6", "R6", "R9"};

  logic clk = 0, rst_n = 0, arm = 0, io_line = 0;
  logic [NSEG-1:0] seg_kind = '0;
  logic [NSEG*CW-1:0] seg_len = '0;
  logic [IW-1:0] seg_last = '0;
  logic [PW-1:0] fire_len = '0;
  logic trig;
  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cardtrig_seq #(.NSEG(NSEG), .CW(CW), .PW(PW)) uut (
    .card_clk(clk), .rst_n(rst_n), .arm(arm), .io_line(io_line),
    .seg_kind(seg_kind), .seg_len(seg_len), .seg_last(seg_last),
    .fire_len(fire_len), .trig(trig));

  task automatic check(input string req, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic settle();
    io_line = 0;
    arm = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(input int i);
    int first = -1, hi = 0;
    settle();
    seg_kind = NSEG'(KIND[i]);
    for (int s = 0; s < NSEG; s++) seg_len[s*CW +: CW] = CW'(LEN[i][s]);
    seg_last = IW'(LAST[i]);
    fire_len = PW'(FW[i]);
    arm = 1;
    @(posedge clk);
    for (int t = 0; t < WIN; t++) begin
      @(negedge clk);
      if (trig) begin
        hi++;
        if (first < 0) first = t;
      end
      if (t == POKE[i]) begin
        arm = 1;
        seg_kind = '1;
        seg_len = '0;
        seg_last = '0;
        fire_len = 8'd9;
      end else begin
        arm = 0;
      end
      io_line = ((t / H) % 2) == 1;
    end
    check(TAG[i], first, EF[i], $sformatf("case %0d trigger cycle", i));
    check(TAG[i], hi, EW[i], $sformatf("case %0d high cycles", i));
  endtask

  initial begin
    #(20ns * 200000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    check("R7", int'(trig), 0, "trig during reset");
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R7", int'(trig), 0, "trig idle after reset");

    for (int i = 0; i < NV; i++) run_case(i);

    // R7: reset in the middle of a cycle segment aborts the sequence
    settle();
    seg_kind = 4'b0001;
    seg_len = '0;
    seg_len[0 +: CW] = 16'd10;
    seg_last = '0;
    fire_len = 8'd1;
    arm = 1;
    @(negedge clk);
    arm = 0;
    repeat (4) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    hi = 0;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (trig) hi++;
    end
    check("R7", hi, 0, "no trigger after mid-run reset");
    run_case(1);

    finish_run();
  end
endmodule